// File: doc/BRIEF.md
# Write-Recovery and Precharge Timing Interlock

This block sits between a memory controller's command scheduler and the device command bus of a DDR2 memory. It gives each of eight banks a write-recovery countdown and a row-precharge countdown. A precharge to a bank is held back until the last data pair of that bank's most recent write burst has been followed by the programmed recovery time. An activate to a bank is held back until the row-precharge time has run since that bank was precharged. The timing values are supplied at run time in clock cycles. They are CAS latency, additive latency, write recovery and row precharge. Write latency is taken as additive plus CAS latency minus one. The burst is four elements long, which is two clocks of data.

The scheduler offers one command at a time with a valid/ready handshake. A held command stays offered and is taken on the first cycle its bank's counters permit it. Every command that is taken appears on the registered command output one cycle later. In cycles with no grant, that output carries NOP. A write with the A10 bit high closes the bank by itself once write recovery ends. Per-bank busy flags tell the scheduler which banks are still timing out.

Top module: `wrpre_guard`

## Requirements
- R1: After reset the command output is NOP (code 0), every bank busy flag is 0, and a NOP request is ready at once.
- R2: Command codes are NOP=0, WRITE=1, PRECHARGE=2, PRECHARGE-ALL=3, ACTIVATE=4. A granted command is driven on out_cmd, out_bank and out_a10 one cycle after the grant. In a cycle with no grant, and for a granted NOP or for codes 5 to 7, out_cmd is 0 in the next cycle.
- R3: A PRECHARGE to a bank whose WRITE was granted in cycle W is granted no earlier than cycle W+AL+CL+1+tWR. If it is held waiting, it is granted in exactly that cycle.
- R4: A PRECHARGE to a bank that has no write recovery pending is granted at once, even while another bank is recovering.
- R5: A PRECHARGE-ALL is held until every bank's write recovery has ended, and it restarts the row-precharge count of all banks.
- R6: An ACTIVATE to a bank precharged in cycle P is granted no earlier than cycle P+tRP. If it is held waiting, it is granted in exactly that cycle.
- R7: A WRITE with A10=1 precharges its bank by itself in the cycle its write recovery ends. An ACTIVATE to that bank is then granted no earlier than tRP cycles later.
- R8: An explicit PRECHARGE to a bank with a self-precharge pending is taken at once. It drives NOP on the output and does not change that bank's timing.
- R9: A bank's busy flag is 1 while its write recovery, pending self-precharge or row-precharge count is active, and 0 once all of these are over.
- R10: A self-precharge and an explicit PRECHARGE of another bank that fall in the same cycle both start their own row-precharge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl | input | CFG_W | CAS latency in cycles |
| cfg_al | input | CFG_W | Additive latency in cycles |
| cfg_twr | input | CFG_W | Write recovery time in cycles |
| cfg_trp | input | CFG_W | Row precharge time in cycles |
| req_valid | input | 1 | Scheduler offers a command |
| req_cmd | input | 3 | Offered command code |
| req_bank | input | BW | Target bank |
| req_a10 | input | 1 | A10 bit (self-precharge on WRITE) |
| req_ready | output | 1 | Offered command is taken this cycle |
| out_cmd | output | 3 | Command driven to the device |
| out_bank | output | BW | Bank driven to the device |
| out_a10 | output | 1 | A10 driven to the device |
| bank_busy | output | NB | Per-bank timing-active flags |

## Verification
Two functions can start in the same cycle. One bank's self-precharge fires when its recovery count reaches zero, and the scheduler can be granted an explicit precharge to a different bank in that cycle. The bench writes bank 5 with A10 high and pads with NOPs so that a precharge to bank 6 is granted in the very cycle bank 5's recovery expires. Both banks must then be busy. An activate to bank 5 must wait exactly tRP-1 stall cycles, and an activate to bank 6 offered afterwards must pass with no stall. That shows both row-precharge counts started together and neither load displaced the other.

// File: rtl/wrpre_pkg.sv
`timescale 1ns/1ps
package wrpre_pkg;

    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_WRITE  = 3'd1,
        CMD_PRE    = 3'd2,
        CMD_PREALL = 3'd3,
        CMD_ACT    = 3'd4
    } cmd_e;

endpackage

// File: rtl/wrpre_bank.sv
`timescale 1ns/1ps
module wrpre_bank #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wr_load,
    input  logic [CNT_W-1:0] rp_load,
    input  logic             wr_hit,
    input  logic             wr_auto,
    input  logic             pre_hit,
    output logic             wr_clear,
    output logic             rp_clear,
    output logic             ap_pend,
    output logic             busy
);

    typedef struct packed {
        logic [CNT_W-1:0] wr;
        logic [CNT_W-1:0] rp;
        logic             ap;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     fire_auto;

    always_comb begin
        st_d      = st_q;
        fire_auto = st_q.ap && (st_q.wr == '0);

        if (wr_hit) begin
            st_d.wr = wr_load;
            st_d.ap = wr_auto;
        end else if (st_q.wr != '0) begin
            st_d.wr = st_q.wr - CNT_W'(1);
        end

        if (pre_hit || fire_auto) begin
            st_d.rp = rp_load;
            st_d.ap = 1'b0;
        end else if (st_q.rp != '0) begin
            st_d.rp = st_q.rp - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_clear = (st_q.wr == '0);
    assign rp_clear = (st_q.rp == '0);
    assign ap_pend  = st_q.ap;
    assign busy     = !wr_clear || !rp_clear || st_q.ap;

    // R7: a pending self-precharge never overlaps a running row-precharge count
    assert_ap_no_rp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ap |-> (st_q.rp == '0))
        else $error("self-precharge pending while precharge count runs");

    // R7: self-precharge firing starts the row-precharge count
    assert_auto_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ap && (st_q.wr == '0) && (rp_load != '0)) |=> !rp_clear)
        else $error("self-precharge did not start precharge count");

endmodule

// File: rtl/wrpre_gate.sv
`timescale 1ns/1ps
module wrpre_gate
    import wrpre_pkg::*;
#(
    parameter int NB = 8,
    localparam int BW = $clog2(NB)
) (
    input  logic [2:0]    req_cmd,
    input  logic [BW-1:0] req_bank,
    input  logic [NB-1:0] wr_clear,
    input  logic [NB-1:0] rp_clear,
    input  logic [NB-1:0] ap_pend,
    output logic          ready,
    output logic          drop
);

    always_comb begin
        ready = 1'b1;
        drop  = 1'b0;
        case (req_cmd)
            CMD_WRITE: begin
                ready = rp_clear[req_bank] && !ap_pend[req_bank];
            end
            CMD_PRE: begin
                if (ap_pend[req_bank]) begin
                    drop = 1'b1;
                end else begin
                    ready = wr_clear[req_bank];
                end
            end
            CMD_PREALL: begin
                ready = &wr_clear;
            end
            CMD_ACT: begin
                ready = rp_clear[req_bank] && !ap_pend[req_bank];
            end
            default: begin
                drop = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/wrpre_guard.sv
`timescale 1ns/1ps
module wrpre_guard
    import wrpre_pkg::*;
#(
    parameter int NB    = 8,
    parameter int CFG_W = 4,
    parameter int CNT_W = 6,
    localparam int BW   = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_cl,
    input  logic [CFG_W-1:0] cfg_al,
    input  logic [CFG_W-1:0] cfg_twr,
    input  logic [CFG_W-1:0] cfg_trp,
    input  logic             req_valid,
    input  logic [2:0]       req_cmd,
    input  logic [BW-1:0]    req_bank,
    input  logic             req_a10,
    output logic             req_ready,
    output logic [2:0]       out_cmd,
    output logic [BW-1:0]    out_bank,
    output logic             out_a10,
    output logic [NB-1:0]    bank_busy
);

    typedef struct packed {
        logic [2:0]    cmd;
        logic [BW-1:0] bank;
        logic          a10;
    } out_st_t;

    out_st_t          out_d, out_q;
    logic             grant, drop;
    logic [CNT_W-1:0] wr_load, rp_load;
    logic [NB-1:0]    wr_hit, pre_hit, wr_clear, rp_clear, ap_pend;

    // recovery starts at the edge after the last pair: (AL+CL-1) + 2 + tWR, minus the grant cycle
    assign wr_load = CNT_W'(cfg_cl) + CNT_W'(cfg_al) + CNT_W'(cfg_twr);
    assign rp_load = (cfg_trp == '0) ? '0 : (CNT_W'(cfg_trp) - CNT_W'(1));

    wrpre_gate #(.NB(NB)) u_gate (
        .req_cmd  (req_cmd),
        .req_bank (req_bank),
        .wr_clear (wr_clear),
        .rp_clear (rp_clear),
        .ap_pend  (ap_pend),
        .ready    (req_ready),
        .drop     (drop)
    );

    assign grant = req_valid && req_ready;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        assign wr_hit[g]  = grant && (req_cmd == CMD_WRITE) && (req_bank == BW'(g));
        assign pre_hit[g] = grant && !drop &&
                            (((req_cmd == CMD_PRE) && (req_bank == BW'(g))) ||
                             (req_cmd == CMD_PREALL));

        wrpre_bank #(.CNT_W(CNT_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_load  (wr_load),
            .rp_load  (rp_load),
            .wr_hit   (wr_hit[g]),
            .wr_auto  (req_a10),
            .pre_hit  (pre_hit[g]),
            .wr_clear (wr_clear[g]),
            .rp_clear (rp_clear[g]),
            .ap_pend  (ap_pend[g]),
            .busy     (bank_busy[g])
        );
    end

    always_comb begin
        out_d = '0;
        if (grant) begin
            out_d.cmd  = drop ? 3'(CMD_NOP) : req_cmd;
            out_d.bank = req_bank;
            out_d.a10  = req_a10;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_cmd  = out_q.cmd;
    assign out_bank = out_q.bank;
    assign out_a10  = out_q.a10;

    // R2: no grant means NOP on the bus next cycle
    assert_idle_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> (out_cmd == 3'(CMD_NOP)))
        else $error("command driven without grant");

    // R3: precharge only after the bank's write recovery ended
    assert_pre_after_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && (req_cmd == CMD_PRE) && !ap_pend[req_bank]) |-> wr_clear[req_bank])
        else $error("precharge inside write recovery");

    // R5: precharge-all only when no bank is recovering
    assert_preall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && (req_cmd == CMD_PREALL)) |-> (&wr_clear))
        else $error("precharge-all inside write recovery");

    // R6: activate only after row precharge time
    assert_act_after_rp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && (req_cmd == CMD_ACT)) |-> (rp_clear[req_bank] && !ap_pend[req_bank]))
        else $error("activate inside row precharge time");

    // R8: a precharge to a self-precharging bank leaves the bus idle
    assert_drop_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && (req_cmd == CMD_PRE) && ap_pend[req_bank]) |=> (out_cmd == 3'(CMD_NOP)))
        else $error("rejected precharge reached the bus");

endmodule

// File: tb/test_wrpre_guard.sv
`timescale 1ns/1ps
module test_wrpre_guard;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] cfg_cl, cfg_al, cfg_twr, cfg_trp;
    logic       req_valid;
    logic [2:0] req_cmd;
    logic [2:0] req_bank;
    logic       req_a10;
    logic       req_ready;
    logic [2:0] out_cmd;
    logic [2:0] out_bank;
    logic       out_a10;
    logic [7:0] bank_busy;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    wrpre_guard i_wrpre_guard (
        .clk(clk), .rst_n(rst_n),
        .cfg_cl(cfg_cl), .cfg_al(cfg_al), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank), .req_a10(req_a10),
        .req_ready(req_ready), .out_cmd(out_cmd), .out_bank(out_bank), .out_a10(out_a10),
        .bank_busy(bank_busy)
    );

    // row: cmd[17:15] bank[14:12] a10[11] stalls[10:3] out_cmd[2:0]; CL3 AL0 tWR3 tRP3
    localparam logic [17:0] VEC [12] = '{
        {3'd1, 3'd0, 1'b0, 8'd0, 3'd1},  // R2 write bank 0
        {3'd2, 3'd1, 1'b0, 8'd0, 3'd2},  // R4 other bank not held
        {3'd2, 3'd0, 1'b0, 8'd5, 3'd2},  // R3 held to W+7
        {3'd4, 3'd0, 1'b0, 8'd2, 3'd4},  // R6 tRP after precharge
        {3'd1, 3'd2, 1'b1, 8'd0, 3'd1},  // R7 write with self-precharge
        {3'd2, 3'd2, 1'b0, 8'd0, 3'd0},  // R8 rejected precharge
        {3'd4, 3'd2, 1'b0, 8'd8, 3'd4},  // R7 activate after self-precharge
        {3'd1, 3'd3, 1'b0, 8'd0, 3'd1},  // R2
        {3'd1, 3'd4, 1'b0, 8'd0, 3'd1},  // R2
        {3'd3, 3'd0, 1'b0, 8'd6, 3'd3},  // R5 precharge-all waits for bank 4
        {3'd4, 3'd3, 1'b0, 8'd2, 3'd4},  // R5 precharge-all restarted tRP
        {3'd7, 3'd0, 1'b0, 8'd0, 3'd0}   // R2 unknown code
    };

    function automatic string vec_tag(input int i);
        case (i)
            1:       return "R4";
            2:       return "R3";
            3:       return "R6";
            4, 6:    return "R7";
            5:       return "R8";
            9, 10:   return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called just after a falling edge; returns stall cycles and the next-cycle output
    task automatic send(input logic [2:0] c, input logic [2:0] b, input logic a,
                        output int st, output logic [2:0] oc);
        req_valid = 1'b1; req_cmd = c; req_bank = b; req_a10 = a; st = 0;
        #1;
        while (!req_ready && st < 200) begin
            @(negedge clk); #1; st++;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_cmd = 3'd0; req_bank = 3'd0; req_a10 = 1'b0;
        oc = out_cmd;
    endtask

    task automatic set_cfg(input int cl, input int al, input int twr, input int trp);
        cfg_cl = 4'(cl); cfg_al = 4'(al); cfg_twr = 4'(twr); cfg_trp = 4'(trp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int st;
        logic [2:0] oc;
        rst_n = 1'b0; req_valid = 1'b0; req_cmd = 3'd0; req_bank = 3'd0; req_a10 = 1'b0;
        set_cfg(3, 0, 3, 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_cmd == 3'd0, "R1 out_cmd", int'(out_cmd), 0);
        chk(bank_busy == 8'h00, "R1 busy", int'(bank_busy), 0);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        @(negedge clk);

        for (int i = 0; i < 12; i++) begin
            send(VEC[i][17:15], VEC[i][14:12], VEC[i][11], st, oc);
            chk(st == int'(VEC[i][10:3]), {vec_tag(i), " stall"}, st, int'(VEC[i][10:3]));
            chk(oc == VEC[i][2:0], {vec_tag(i), " out_cmd"}, int'(oc), int'(VEC[i][2:0]));
        end

        repeat (20) @(negedge clk);
        #1;
        chk(bank_busy == 8'h00, "R9 idle busy", int'(bank_busy), 0);

        // R3 with other latencies: AL+CL+1+tWR = 12 cycles, offered one cycle after write
        set_cfg(4, 2, 5, 3);
        @(negedge clk);
        send(3'd1, 3'd7, 1'b0, st, oc);
        chk(bank_busy[7] == 1'b1, "R9 busy after write", int'(bank_busy[7]), 1);
        chk(out_bank == 3'd7, "R2 out_bank", int'(out_bank), 7);
        chk(out_a10 == 1'b0, "R2 out_a10", int'(out_a10), 0);
        send(3'd2, 3'd7, 1'b0, st, oc);
        chk(st == 11, "R3 long latency stall", st, 11);
        send(3'd4, 3'd7, 1'b0, st, oc);
        chk(st == 2, "R6 act stall", st, 2);

        // R10: self-precharge of bank 5 and explicit precharge of bank 6 in one cycle
        set_cfg(3, 0, 3, 3);
        repeat (10) @(negedge clk);
        send(3'd1, 3'd5, 1'b1, st, oc);
        chk(out_a10 == 1'b1, "R2 out_a10 high", int'(out_a10), 1);
        for (int n = 0; n < 6; n++) send(3'd0, 3'd0, 1'b0, st, oc);
        send(3'd2, 3'd6, 1'b0, st, oc);
        chk(st == 0, "R10 pre stall", st, 0);
        chk(bank_busy[6:5] == 2'b11, "R10 both busy", int'(bank_busy[6:5]), 3);
        send(3'd4, 3'd5, 1'b0, st, oc);
        chk(st == 2, "R10 act bank5 stall", st, 2);
        send(3'd4, 3'd6, 1'b0, st, oc);
        chk(st == 0, "R10 act bank6 stall", st, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule